// File: doc/BRIEF.md
# Transmit Descriptor Ring Sequencer

This block is the control sequencer of a descriptor-driven transmit DMA engine. It walks a ring of four-word descriptors in a shared memory. It reads each descriptor's ownership word and then its control word. A descriptor that does not end a frame is closed as soon as it has been taken. Once the descriptor that ends a frame has been taken, the frame is released to the MAC with a one-cycle `frame_go` pulse.

Status write-back is deferred by one frame. The descriptor of a released frame stays pending. Its status (and its timestamp, when that descriptor asks for one) is collected and written back only after the next frame has been released, or while the sequencer is suspended. The write-back clears the ownership bit, which returns the descriptor to the CPU. A completion flag is raised when the descriptor requests one.

The sequencer suspends when it meets a descriptor it does not own, and when a transmit underflow is reported. While suspended it still retires a pending frame's status. A `kick` strobe resumes it. On resume it goes first to the status wait if a frame is still pending, and to the ring walk otherwise.

Top module: `tx_dsc_seq`

## Requirements
- R1: After reset the sequencer is suspended (`running`=0), all three flags and `irq` are 0, and it makes no memory access until `kick`.
- R2: A fetch reads word 0 of the descriptor at the ring pointer. If bit 31 (owned-by-DMA) is 0, `nodesc_flag` is set and the sequencer suspends without reading further.
- R3: A descriptor whose control word (word 1) has bit 30 (frame end) clear is closed right after being taken: word 0 is written to all zeros, and no `frame_go` is issued for it.
- R4: Each descriptor with frame end set yields exactly one single-cycle `frame_go`. The sequencer then fetches again without waiting for that frame's status when no other frame is pending.
- R5: The status of a pending frame is written back only once it has arrived, and also after the timestamp has arrived if that descriptor's word 1 bit 27 (timestamp request) is set. Word 0 becomes {bit 31 = 0, status in bits [SW-1:0]}, and the timestamp goes into word 2.
- R6: `done_flag` is set by a write-back only if the descriptor's word 1 bit 31 (completion request) is 1. `irq` equals `done_flag` AND `int_en`.
- R7: A written-back status with bit 1 (underflow) set raises `undr_flag` and leaves the sequencer suspended.
- R8: While suspended, a pending frame whose status (and timestamp if requested) arrives is written back and flagged as in R5/R6, and the sequencer stays suspended.
- R9: `kick` while suspended clears `undr_flag` and resumes: to the status wait if a frame is pending, otherwise to a fetch.
- R10: The ring pointer steps by DESC_WORDS words per taken descriptor and returns to RING_BASE after a descriptor with word 1 bit 28 (ring end) set.
- R11: `flag_clr` is write-one-to-clear: bit 0 clears `done_flag`, bit 1 clears `nodesc_flag`, bit 2 clears `undr_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kick | input | 1 | Poll-demand strobe that resumes a suspended sequencer |
| int_en | input | 1 | Enables `irq` from the completion flag |
| flag_clr | input | 3 | Write-one-to-clear for the flags |
| mem_rd | output | 1 | Descriptor memory read; data returns the next cycle |
| mem_wr | output | 1 | Descriptor memory write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after `mem_rd` |
| stat_valid | input | 1 | Frame status strobe from the MAC |
| stat_data | input | SW | Frame status; bit 1 marks underflow |
| ts_valid | input | 1 | Timestamp strobe from the MAC |
| ts_data | input | TW | Frame timestamp |
| frame_go | output | 1 | One-cycle pulse releasing a frame to the MAC |
| running | output | 1 | 1 unless suspended |
| done_flag | output | 1 | Completion flag |
| nodesc_flag | output | 1 | Descriptor-not-owned flag |
| undr_flag | output | 1 | Transmit underflow flag |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with an 8-bit word address and RING_BASE at 16. This places a four-descriptor ring away from address zero, so a wrap back to the base can be told apart from an overflow into unused memory. Descriptor words and status values are chosen so that every field position named above is exercised with both values. This reaches both write-back paths (deferred while running, and retired while suspended), the timestamp hold-off, and a resume into a frame that is still pending.

// File: rtl/tx_dsc_pkg.sv
package tx_dsc_pkg;
  // word 0
  localparam int OWN_BIT  = 31;
  // word 1
  localparam int IC_BIT   = 31;
  localparam int LAST_BIT = 30;
  localparam int EOR_BIT  = 28;
  localparam int TSE_BIT  = 27;
  // status
  localparam int UF_BIT   = 1;

  typedef enum logic [3:0] {
    ST_SUSP, ST_RD0, ST_CK0, ST_RD1, ST_CK1, ST_CLOSE,
    ST_HAND, ST_WAIT, ST_WB0, ST_WB2, ST_FIN
  } seq_st_e;
endpackage

// File: rtl/tx_dsc_ring.sv
module tx_dsc_ring #(
  parameter int AW        = 8,
  parameter int RING_BASE = 0,
  parameter int STEP      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          wrap,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] BASE_A = AW'(RING_BASE);
  localparam logic [AW-1:0] STEP_A = AW'(STEP);

  logic [AW-1:0] ptr_nx;

  always_comb begin
    ptr_nx = ptr;
    if (adv) ptr_nx = wrap ? BASE_A : ptr + STEP_A;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= BASE_A;
    else if (adv) ptr <= ptr_nx;
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (ptr == $past(ptr) + STEP_A) || (ptr == BASE_A)); // R10
endmodule

// File: rtl/tx_dsc_stcap.sv
module tx_dsc_stcap #(
  parameter int SW = 16,
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stat_valid,
  input  logic [SW-1:0] stat_in,
  input  logic          ts_valid,
  input  logic [TW-1:0] ts_in,
  input  logic          consume,
  output logic          have_stat,
  output logic          have_ts,
  output logic [SW-1:0] stat_q,
  output logic [TW-1:0] ts_q
);
  logic hs_nx, ht_nx;

  always_comb begin
    hs_nx = have_stat;
    ht_nx = have_ts;
    if (consume) begin
      hs_nx = 1'b0;
      ht_nx = 1'b0;
    end
    if (stat_valid) hs_nx = 1'b1;
    if (ts_valid)   ht_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_stat <= 1'b0;
      have_ts   <= 1'b0;
    end else begin
      have_stat <= hs_nx;
      have_ts   <= ht_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          stat_q <= '0;
    else if (stat_valid) stat_q <= stat_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ts_q <= '0;
    else if (ts_valid) ts_q <= ts_in;
  end
endmodule

// File: rtl/tx_dsc_flags.sv
module tx_dsc_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_done,
  input  logic       set_nodesc,
  input  logic       set_undr,
  input  logic       kick_clr,
  input  logic [2:0] flag_clr,
  input  logic       int_en,
  output logic       done_flag,
  output logic       nodesc_flag,
  output logic       undr_flag,
  output logic       irq
);
  logic done_nx, nodesc_nx, undr_nx;

  always_comb begin
    done_nx   = set_done   | (done_flag   & ~flag_clr[0]);
    nodesc_nx = set_nodesc | (nodesc_flag & ~flag_clr[1]);
    undr_nx   = set_undr   | (undr_flag   & ~flag_clr[2] & ~kick_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag   <= 1'b0;
      nodesc_flag <= 1'b0;
      undr_flag   <= 1'b0;
    end else begin
      done_flag   <= done_nx;
      nodesc_flag <= nodesc_nx;
      undr_flag   <= undr_nx;
    end
  end

  assign irq = done_flag & int_en;
endmodule

// File: rtl/tx_dsc_fsm.sv
module tx_dsc_fsm
  import tx_dsc_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int SW = 16,
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kick,
  input  logic [AW-1:0] ptr,
  input  logic [DW-1:0] mem_rdata,
  input  logic          have_stat,
  input  logic          have_ts,
  input  logic [SW-1:0] stat_q,
  input  logic [TW-1:0] ts_q,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          ptr_adv,
  output logic          ptr_wrap,
  output logic          frame_go,
  output logic          running,
  output logic          consume,
  output logic          set_done,
  output logic          set_nodesc,
  output logic          set_undr,
  output logic          kick_clr
);
  localparam logic [AW-1:0] OFS_CTL = AW'(1);
  localparam logic [AW-1:0] OFS_TS  = AW'(2);

  seq_st_e       st_q, st_nx;
  logic [AW-1:0] cur_addr, cur_addr_nx, pend_addr, pend_addr_nx;
  logic          cur_ic, cur_ic_nx, cur_tse, cur_tse_nx;
  logic          pend_ic, pend_ic_nx, pend_tse, pend_tse_nx;
  logic          pend_v, pend_v_nx, hand_new, hand_new_nx;
  logic          from_susp, from_susp_nx;
  logic          ready;
  logic          unused_rd;

  assign unused_rd = ^mem_rdata;
  assign ready     = have_stat && (!pend_tse || have_ts);
  assign running   = (st_q != ST_SUSP);

  always_comb begin
    st_nx        = st_q;
    cur_addr_nx  = cur_addr;
    cur_ic_nx    = cur_ic;
    cur_tse_nx   = cur_tse;
    pend_addr_nx = pend_addr;
    pend_ic_nx   = pend_ic;
    pend_tse_nx  = pend_tse;
    pend_v_nx    = pend_v;
    hand_new_nx  = hand_new;
    from_susp_nx = from_susp;
    mem_rd       = 1'b0;
    mem_wr       = 1'b0;
    mem_addr     = ptr;
    mem_wdata    = '0;
    ptr_adv      = 1'b0;
    ptr_wrap     = 1'b0;
    frame_go     = 1'b0;
    consume      = 1'b0;
    set_done     = 1'b0;
    set_nodesc   = 1'b0;
    set_undr     = 1'b0;
    kick_clr     = 1'b0;
    case (st_q)
      ST_SUSP: begin
        if (kick) begin
          kick_clr     = 1'b1;
          from_susp_nx = 1'b0;
          st_nx        = pend_v ? ST_WAIT : ST_RD0;
        end else if (pend_v && ready) begin
          from_susp_nx = 1'b1;
          st_nx        = ST_WB0;
        end
      end
      ST_RD0: begin
        mem_rd = 1'b1;
        st_nx  = ST_CK0;
      end
      ST_CK0: begin
        if (!mem_rdata[OWN_BIT]) begin
          set_nodesc = 1'b1;
          st_nx      = ST_SUSP;
        end else begin
          st_nx = ST_RD1;
        end
      end
      ST_RD1: begin
        mem_rd   = 1'b1;
        mem_addr = ptr + OFS_CTL;
        st_nx    = ST_CK1;
      end
      ST_CK1: begin
        cur_addr_nx = ptr;
        cur_ic_nx   = mem_rdata[IC_BIT];
        cur_tse_nx  = mem_rdata[TSE_BIT];
        ptr_adv     = 1'b1;
        ptr_wrap    = mem_rdata[EOR_BIT];
        st_nx       = mem_rdata[LAST_BIT] ? ST_HAND : ST_CLOSE;
      end
      ST_CLOSE: begin
        mem_wr   = 1'b1;
        mem_addr = cur_addr;
        st_nx    = ST_RD0;
      end
      ST_HAND: begin
        frame_go = 1'b1;
        if (pend_v) begin
          hand_new_nx = 1'b1;
          st_nx       = ST_WAIT;
        end else begin
          pend_addr_nx = cur_addr;
          pend_ic_nx   = cur_ic;
          pend_tse_nx  = cur_tse;
          pend_v_nx    = 1'b1;
          st_nx        = ST_RD0;
        end
      end
      ST_WAIT: begin
        if (ready) st_nx = ST_WB0;
      end
      ST_WB0: begin
        mem_wr            = 1'b1;
        mem_addr          = pend_addr;
        mem_wdata[SW-1:0] = stat_q;
        st_nx             = pend_tse ? ST_WB2 : ST_FIN;
      end
      ST_WB2: begin
        mem_wr    = 1'b1;
        mem_addr  = pend_addr + OFS_TS;
        mem_wdata = DW'(ts_q);
        st_nx     = ST_FIN;
      end
      ST_FIN: begin
        consume  = 1'b1;
        set_done = pend_ic;
        set_undr = stat_q[UF_BIT];
        if (hand_new) begin
          pend_addr_nx = cur_addr;
          pend_ic_nx   = cur_ic;
          pend_tse_nx  = cur_tse;
          hand_new_nx  = 1'b0;
        end else begin
          pend_v_nx = 1'b0;
        end
        st_nx = (from_susp || stat_q[UF_BIT]) ? ST_SUSP : ST_RD0;
      end
      default: st_nx = ST_SUSP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_SUSP;
      cur_addr  <= '0;
      cur_ic    <= 1'b0;
      cur_tse   <= 1'b0;
      pend_addr <= '0;
      pend_ic   <= 1'b0;
      pend_tse  <= 1'b0;
      pend_v    <= 1'b0;
      hand_new  <= 1'b0;
      from_susp <= 1'b0;
    end else begin
      st_q      <= st_nx;
      cur_addr  <= cur_addr_nx;
      cur_ic    <= cur_ic_nx;
      cur_tse   <= cur_tse_nx;
      pend_addr <= pend_addr_nx;
      pend_ic   <= pend_ic_nx;
      pend_tse  <= pend_tse_nx;
      pend_v    <= pend_v_nx;
      hand_new  <= hand_new_nx;
      from_susp <= from_susp_nx;
    end
  end

  AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_go |=> !frame_go); // R4
  AST_NO_ACCESS_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !kick) |=> !mem_rd); // R1
endmodule

// File: rtl/tx_dsc_seq.sv
module tx_dsc_seq #(
  parameter int AW         = 8,
  parameter int DW         = 32,
  parameter int SW         = 16,
  parameter int TW         = 32,
  parameter int RING_BASE  = 0,
  parameter int DESC_WORDS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kick,
  input  logic          int_en,
  input  logic [2:0]    flag_clr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          stat_valid,
  input  logic [SW-1:0] stat_data,
  input  logic          ts_valid,
  input  logic [TW-1:0] ts_data,
  output logic          frame_go,
  output logic          running,
  output logic          done_flag,
  output logic          nodesc_flag,
  output logic          undr_flag,
  output logic          irq
);
  logic [1:0]    rst_sync;
  logic          rst_q_n;
  logic [AW-1:0] ptr;
  logic          ptr_adv, ptr_wrap, consume;
  logic          have_stat, have_ts;
  logic [SW-1:0] stat_q;
  logic [TW-1:0] ts_q;
  logic          set_done, set_nodesc, set_undr, kick_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  tx_dsc_ring #(.AW(AW), .RING_BASE(RING_BASE), .STEP(DESC_WORDS)) u_ring (
    .clk(clk), .rst_n(rst_q_n), .adv(ptr_adv), .wrap(ptr_wrap), .ptr(ptr));

  tx_dsc_stcap #(.SW(SW), .TW(TW)) u_stcap (
    .clk(clk), .rst_n(rst_q_n), .stat_valid(stat_valid), .stat_in(stat_data),
    .ts_valid(ts_valid), .ts_in(ts_data), .consume(consume),
    .have_stat(have_stat), .have_ts(have_ts), .stat_q(stat_q), .ts_q(ts_q));

  tx_dsc_fsm #(.AW(AW), .DW(DW), .SW(SW), .TW(TW)) u_fsm (
    .clk(clk), .rst_n(rst_q_n), .kick(kick), .ptr(ptr), .mem_rdata(mem_rdata),
    .have_stat(have_stat), .have_ts(have_ts), .stat_q(stat_q), .ts_q(ts_q),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .ptr_adv(ptr_adv), .ptr_wrap(ptr_wrap), .frame_go(frame_go), .running(running),
    .consume(consume), .set_done(set_done), .set_nodesc(set_nodesc),
    .set_undr(set_undr), .kick_clr(kick_clr));

  tx_dsc_flags u_flags (
    .clk(clk), .rst_n(rst_q_n), .set_done(set_done), .set_nodesc(set_nodesc),
    .set_undr(set_undr), .kick_clr(kick_clr), .flag_clr(flag_clr), .int_en(int_en),
    .done_flag(done_flag), .nodesc_flag(nodesc_flag), .undr_flag(undr_flag), .irq(irq));

  AST_NODESC_SUSPENDS: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(nodesc_flag) |-> !running); // R2
  AST_UNDR_SUSPENDS: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(undr_flag) |-> !running); // R7
  AST_KICK_CLEARS_UNDR: assert property (@(posedge clk) disable iff (!rst_q_n)
    (kick && !running) |=> !undr_flag); // R9
  AST_DONE_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(done_flag) |-> $past(mem_wr, 2)); // R6
endmodule

// File: tb/tb_tx_dsc_seq.sv
`timescale 1ns/1ps
module tb_tx_dsc_seq;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int SW = 16;
  localparam int TW = 32;
  localparam int B  = 16;
  localparam logic [31:0] OWN = 32'h8000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kick = 1'b0, int_en = 1'b0;
  logic [2:0] flag_clr = 3'b000;
  logic mem_rd, mem_wr;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic stat_valid = 1'b0, ts_valid = 1'b0;
  logic [SW-1:0] stat_data = '0;
  logic [TW-1:0] ts_data = '0;
  logic frame_go, running, done_flag, nodesc_flag, undr_flag, irq;

  logic tb_we = 1'b0;
  logic [AW-1:0] tb_addr = '0;
  logic [DW-1:0] tb_data = '0;
  logic [DW-1:0] mem [256];
  int rd_cnt = 0, go_cnt = 0;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  tx_dsc_seq #(.AW(AW), .DW(DW), .SW(SW), .TW(TW), .RING_BASE(B), .DESC_WORDS(4)) dut (
    .clk(clk), .rst_n(rst_n), .kick(kick), .int_en(int_en), .flag_clr(flag_clr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .stat_valid(stat_valid), .stat_data(stat_data),
    .ts_valid(ts_valid), .ts_data(ts_data), .frame_go(frame_go), .running(running),
    .done_flag(done_flag), .nodesc_flag(nodesc_flag), .undr_flag(undr_flag), .irq(irq));

  always @(posedge clk) begin
    if (tb_we)       mem[tb_addr] <= tb_data;
    else if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_rd) rd_cnt <= rd_cnt + 1;
    if (frame_go) go_cnt <= go_cnt + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_mem(input int a, input logic [31:0] d);
    tb_we = 1'b1; tb_addr = AW'(a); tb_data = d;
    tick(1);
    tb_we = 1'b0;
  endtask

  task automatic do_kick();
    kick = 1'b1; tick(1); kick = 1'b0;
  endtask

  task automatic do_clr(input logic [2:0] c);
    flag_clr = c; tick(1); flag_clr = 3'b000;
  endtask

  task automatic send_stat(input logic [15:0] s);
    stat_valid = 1'b1; stat_data = s; tick(1); stat_valid = 1'b0;
  endtask

  task automatic send_ts(input logic [31:0] t);
    ts_valid = 1'b1; ts_data = t; tick(1); ts_valid = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  // {ic, tse, eor, ie, status[15:0], ts[31:0]}
  localparam logic [51:0] VEC [5] = '{
    {1'b1, 1'b0, 1'b0, 1'b1, 16'h0011, 32'h0000_0000},
    {1'b0, 1'b1, 1'b0, 1'b1, 16'h0020, 32'hCAFE_0001},
    {1'b1, 1'b1, 1'b0, 1'b0, 16'h0302, 32'h1234_5678},
    {1'b1, 1'b0, 1'b1, 1'b1, 16'h0040, 32'h0000_0000},
    {1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 32'h0000_0000}
  };

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int rd0, go0;
    for (int i = 0; i < 256; i++) wr_mem(i, 32'h0);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    check("R1 running", {31'b0, running}, 0);
    check("R1 flags", {29'b0, done_flag, nodesc_flag, undr_flag}, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 rd/wr", {30'b0, mem_rd, mem_wr}, 0);
    rd0 = rd_cnt;
    tick(5);
    check("R1 no reads before kick", rd_cnt - rd0, 0);

    // R2 unowned descriptor at base
    rd0 = rd_cnt; go0 = go_cnt;
    do_kick(); tick(20);
    check("R2 single read", rd_cnt - rd0, 1);
    check("R2 nodesc_flag", {31'b0, nodesc_flag}, 1);
    check("R2 suspended", {31'b0, running}, 0);
    check("R2 no frame", go_cnt - go0, 0);
    do_clr(3'b010);
    check("R11 nodesc cleared", {31'b0, nodesc_flag}, 0);

    // table walk: one single-descriptor frame per vector, retired while suspended
    for (int k = 0; k < 5; k++) begin
      logic ic, tse, eor, ie;
      logic [15:0] st;
      logic [31:0] ts;
      int a;
      {ic, tse, eor, ie, st, ts} = VEC[k];
      a = (k == 4) ? B : B + 4 * k;
      wr_mem(a + 1, {ic, 1'b1, 1'b0, eor, tse, 27'b0});
      wr_mem(a + 2, 32'h0);
      wr_mem(a, OWN);
      int_en = ie;
      go0 = go_cnt;
      do_kick(); tick(20);
      check("R4 one frame_go", go_cnt - go0, 1);
      check("R9 kick cleared undr", {31'b0, undr_flag}, 0);
      check("R2 suspend on next", {30'b0, nodesc_flag, running}, 2);
      check("R5 status deferred", mem[a], OWN);
      send_stat(st);
      if (tse) begin
        tick(6);
        check("R5 waits for timestamp", mem[a], OWN);
        send_ts(ts);
      end
      tick(10);
      check("R8 word0 written back", mem[a], {16'h0, st});
      if (tse) check("R5 timestamp word", mem[a + 2], ts);
      check("R6 done_flag", {31'b0, done_flag}, {31'b0, ic});
      check("R6 irq", {31'b0, irq}, {31'b0, ic & ie});
      check("R7 undr_flag", {31'b0, undr_flag}, {31'b0, st[1]});
      check("R8 stays suspended", {31'b0, running}, 0);
      do_clr((k == 2) ? 3'b111 : 3'b011);
      check("R11 flags cleared", {30'b0, done_flag, nodesc_flag}, 0);
      if (k == 2) check("R11 undr cleared", {31'b0, undr_flag}, 0);
    end

    // directed: multi-descriptor frame, running write-back, ring wrap
    int_en = 1'b1;
    wr_mem(B + 5, 32'h0000_0000);
    wr_mem(B + 9, 32'hC000_0000);
    wr_mem(B + 13, 32'h5000_0000);
    wr_mem(B + 17, 32'h4000_0000);
    wr_mem(B + 4, OWN);
    wr_mem(B + 8, OWN);
    wr_mem(B + 12, OWN);
    wr_mem(B + 16, OWN);
    go0 = go_cnt;
    do_kick(); tick(25);
    check("R3 intermediate closed", mem[B + 4], 0);
    check("R3 frames released", go_cnt - go0, 2);
    check("R5 waits while running", {31'b0, running}, 1);
    check("R5 not yet written", mem[B + 8], OWN);
    send_stat(16'h00A5);
    tick(15);
    check("R5 running write-back", mem[B + 8], 32'h0000_00A5);
    check("R6 done on request", {31'b0, done_flag}, 1);
    check("R10 wrapped to base", go_cnt - go0, 2);
    check("R10 suspended at base", {30'b0, nodesc_flag, running}, 2);
    check("R4 new frame pending", mem[B + 12], OWN);
    do_clr(3'b011);
    send_stat(16'h0002);
    tick(10);
    check("R8 retired in suspend", mem[B + 12], 32'h0000_0002);
    check("R7 underflow flagged", {31'b0, undr_flag}, 1);
    check("R6 no done without request", {31'b0, done_flag}, 0);
    check("R8 still suspended", {31'b0, running}, 0);

    // directed: resume into a pending frame with timestamp
    wr_mem(B + 1, 32'hC800_0000);
    wr_mem(B, OWN);
    go0 = go_cnt;
    do_kick(); tick(20);
    check("R9 undr cleared by kick", {31'b0, undr_flag}, 0);
    check("R4 frame out", go_cnt - go0, 1);
    check("R2 suspended again", {31'b0, running}, 0);
    do_clr(3'b010);
    do_kick(); tick(10);
    check("R9 resumes into status wait", {31'b0, running}, 1);
    send_stat(16'h0033);
    tick(8);
    check("R5 held for timestamp", mem[B], OWN);
    send_ts(32'hDEAD_BEEF);
    tick(12);
    check("R5 word0 after ts", mem[B], 32'h0000_0033);
    check("R5 ts word", mem[B + 2], 32'hDEAD_BEEF);
    check("R6 done set", {31'b0, done_flag}, 1);
    check("R9 back to suspend", {31'b0, running}, 0);
    int_en = 1'b0;
    tick(1);
    check("R6 irq gated", {31'b0, irq}, 0);

    summary();
  end
endmodule